// File: doc/BRIEF.md
# Single DMA Transfer Channel with Bus Attribute Tagging

This block is one DMA channel that copies a run of bytes from a source region to a destination region over a simple valid/ready master bus. Software loads a source base, a destination base and a byte count through a small register write port. It then writes a control word that sets the source operand width, the destination operand width, the attribute policy, the addressing mode and the request mode, and that starts the transfer. Data passes through a 16-byte staging buffer, so the two sides can use different widths. The channel reads until it holds one transfer unit, which is the larger of the two widths. It then writes that unit out.

Every access carries a 2-bit transfer-type tag and a 3-bit modifier. The modifier holds a channel code and a single-address marker. A peripheral paces the channel through an active-low request input. In cycle-steal mode each request moves one unit and the channel then leaves the bus. In continuous mode a single request drains the whole count.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `bus_valid` are 0 and `bus_tt`/`bus_tm` are 0. While not busy, the channel never raises `bus_valid`.
- R2: A control write (`reg_sel`=3) with bit0 set starts a transfer if the count is non-zero and a multiple of the unit. The unit is max(source,destination) bytes in dual mode and the source size in single-address mode. Otherwise `err` is set and `busy` stays 0. Writing bit9=1 clears `err`. If an invalid start and the clear fall in the same write, the set wins.
- R3: In dual-address mode the channel makes unit/src reads (`bus_write`=0), then unit/dst writes (`bus_write`=1). `bus_size` carries the size code: 00=8, 01=16, 10=32, 11=128 bits. Data is right-justified on the bus, and the byte stream order is preserved through the buffer.
- R4: Each address advances by its own side's size after every access, starting from the programmed base. The count drops by the destination size per write. When it reaches zero, `done` is set and `busy` clears at the same edge.
- R5: Every access drives `bus_tt`=2'b01. `bus_tm[0]` equals the single-address control bit (bit6).
- R6: `bus_tm[2:1]` carries the channel code: 01 for CHAN_ID 0, 10 for CHAN_ID 1. With AT (bit5) set, the code appears on every access. With AT clear, it appears only on the access that brings the count to zero, and 00 is driven otherwise. 11 is never driven.
- R7: In single-address mode (bit6=1) there is one read access per source operand at the source address. The count drops by the source size and no write access occurs.
- R8: `dreq_n` is active low and level-sampled. While it is high, a started channel waiting for a request makes no access and stays busy.
- R9: With bit7=0 (cycle-steal), each request moves one unit, after which `bus_valid` drops for at least one cycle. With bit7=1 (continuous), one request runs the count to zero with no gap after the first access.
- R10: While `bus_valid`=1 and `bus_ready`=0, the next cycle keeps `bus_valid` high and holds address, direction, size, write data and tags unchanged.
- R11: `done` is sticky. A control write with bit8=1 clears it. If completion falls in the same cycle as that clear, `done` ends up set.
- R12: While busy, writes to the base, count and control configuration are ignored, and a start is ignored. A later transfer started with no re-programming uses the earlier programmed bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 source base, 1 destination base, 2 byte count, 3 control |
| reg_wdata | input | AW | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky start-refused flag |
| dreq_n | input | 1 | Active-low transfer request |
| bus_valid | output | 1 | Access request |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Byte address |
| bus_size | output | 2 | Operand size code |
| bus_wdata | output | DW | Write data, right-justified |
| bus_rdata | input | DW | Read data, right-justified |
| bus_ready | input | 1 | Access accepted this cycle |
| bus_tt | output | 2 | Transfer-type tag |
| bus_tm | output | 3 | Modifier: channel code in [2:1], single-address flag in [0] |

## Verification
Two flag updates can land in one cycle. The first is the completing write handshake that sets `done`, arriving together with a software write that clears `done`. The bench holds `bus_ready` low on the final write until it is pending, then raises it in the same cycle as the clearing control write, and expects `done` to read 1 afterwards. The same approach is used for `err`: one control write both clears `err` and asks for a start with an illegal count, and the flag must stay set.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_SACC
    } seq_state_e;

    typedef struct packed {
        logic [1:0] ssz;
        logic [1:0] dsz;
        logic       at;
        logic       saa;
        logic       cont;
    } xfer_cfg_t;

    localparam int CB_START  = 0;
    localparam int CB_SSZ    = 1;
    localparam int CB_DSZ    = 3;
    localparam int CB_AT     = 5;
    localparam int CB_SAA    = 6;
    localparam int CB_CONT   = 7;
    localparam int CB_CLRDN  = 8;
    localparam int CB_CLRERR = 9;

    // log2 of the operand size in bytes
    function automatic logic [2:0] size_lg(input logic [1:0] code);
        return (code == 2'b11) ? 3'd4 : {1'b0, code};
    endfunction

endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
    import dma_ch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          eng_busy,
    input  logic          done_evt,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base,
    output logic [AW-1:0] byte_cnt,
    output xfer_cfg_t     cfg,
    output logic          start,
    output logic          busy,
    output logic          done,
    output logic          err
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] cnt;
        xfer_cfg_t     cfg;
        logic          start;
        logic          done;
        logic          err;
    } regs_t;

    regs_t q, d;

    logic          blocked;
    xfer_cfg_t     new_cfg;
    logic [2:0]    unit_lg;
    logic [AW-1:0] unit_mask;
    logic [2:0]    s_lg, d_lg;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        blocked  = eng_busy | q.start;
        new_cfg.ssz  = reg_wdata[CB_SSZ +: 2];
        new_cfg.dsz  = reg_wdata[CB_DSZ +: 2];
        new_cfg.at   = reg_wdata[CB_AT];
        new_cfg.saa  = reg_wdata[CB_SAA];
        new_cfg.cont = reg_wdata[CB_CONT];
        s_lg     = size_lg(new_cfg.ssz);
        d_lg     = size_lg(new_cfg.dsz);
        unit_lg  = new_cfg.saa ? s_lg : ((s_lg > d_lg) ? s_lg : d_lg);
        unit_mask = (AW'(1) << unit_lg) - AW'(1);

        if (reg_wr) begin
            unique case (reg_sel)
                2'd0: if (!blocked) d.src = reg_wdata;
                2'd1: if (!blocked) d.dst = reg_wdata;
                2'd2: if (!blocked) d.cnt = reg_wdata;
                default: begin
                    if (reg_wdata[CB_CLRDN])  d.done = 1'b0;
                    if (reg_wdata[CB_CLRERR]) d.err  = 1'b0;
                    if (!blocked) begin
                        d.cfg = new_cfg;
                        if (reg_wdata[CB_START]) begin
                            if ((q.cnt == '0) || ((q.cnt & unit_mask) != '0))
                                d.err = 1'b1;
                            else
                                d.start = 1'b1;
                        end
                    end
                end
            endcase
        end
        if (done_evt) d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src_base = q.src;
    assign dst_base = q.dst;
    assign byte_cnt = q.cnt;
    assign cfg      = q.cfg;
    assign start    = q.start;
    assign busy     = eng_busy | q.start;
    assign done     = q.done;
    assign err      = q.err;

endmodule

// File: rtl/dma_ch_stage.sv
module dma_ch_stage #(
    parameter int BUF_BYTES = 16,
    localparam int DW   = BUF_BYTES * 8,
    localparam int OFFW = $clog2(BUF_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [OFFW-1:0] cap_off,
    input  logic [2:0]      cap_lg,
    input  logic [DW-1:0]   cap_data,
    input  logic [OFFW-1:0] ext_off,
    input  logic [2:0]      ext_lg,
    output logic [DW-1:0]   ext_data
);

    typedef struct packed {
        logic [DW-1:0] line;
    } stage_t;

    stage_t q, d;

    function automatic logic [DW-1:0] lane_mask(input logic [2:0] lg);
        int bits;
        bits = 8 << lg;
        if (bits >= DW) return {DW{1'b1}};
        return {DW{1'b1}} >> (DW - bits);
    endfunction

    logic [DW-1:0] cmask;
    int            csh, esh;

    always_comb begin
        d     = q;
        cmask = lane_mask(cap_lg);
        csh   = int'(cap_off) * 8;
        esh   = int'(ext_off) * 8;
        if (cap_en)
            d.line = (q.line & ~(cmask << csh)) | ((cap_data & cmask) << csh);
        ext_data = (q.line >> esh) & lane_mask(ext_lg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
    import dma_ch_pkg::*;
#(
    parameter int AW      = 32,
    parameter int OFFW    = 4,
    parameter int CHAN_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   src_base,
    input  logic [AW-1:0]   dst_base,
    input  logic [AW-1:0]   byte_cnt,
    input  xfer_cfg_t       cfg,
    input  logic            dreq_n,
    input  logic            bus_ready,
    output logic            eng_busy,
    output logic            done_evt,
    output logic            bus_valid,
    output logic            bus_write,
    output logic [AW-1:0]   bus_addr,
    output logic [1:0]      bus_size,
    output logic [1:0]      bus_tt,
    output logic [2:0]      bus_tm,
    output logic            cap_en,
    output logic [OFFW-1:0] cap_off,
    output logic [2:0]      cap_lg,
    output logic [OFFW-1:0] ext_off,
    output logic [2:0]      ext_lg
);

    localparam logic [1:0] CHAN_CODE = (CHAN_ID == 0) ? 2'b01 : 2'b10;
    localparam int         IDXW      = OFFW + 1;

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] sa;
        logic [AW-1:0] da;
        logic [AW-1:0] cnt;
        logic [IDXW-1:0] idx;
        xfer_cfg_t     cf;
    } seq_t;

    seq_t q, d;

    logic [2:0]      slg, dlg, ulg;
    logic [IDXW-1:0] rd_last, wr_last;
    logic [AW-1:0]   s_step, d_step, cnt_next;
    logic            last_acc;
    logic [1:0]      tm_code;

    always_comb begin
        d        = q;
        slg      = size_lg(q.cf.ssz);
        dlg      = size_lg(q.cf.dsz);
        ulg      = (slg > dlg) ? slg : dlg;
        rd_last  = (IDXW'(1) << (ulg - slg)) - IDXW'(1);
        wr_last  = (IDXW'(1) << (ulg - dlg)) - IDXW'(1);
        s_step   = AW'(1) << slg;
        d_step   = AW'(1) << dlg;
        cnt_next = q.cnt;
        last_acc = ((q.st == ST_WRITE) && (q.idx == wr_last) && (q.cnt == d_step)) ||
                   ((q.st == ST_SACC) && (q.cnt == s_step));
        done_evt = last_acc && bus_ready;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_WAIT;
                    d.sa  = src_base;
                    d.da  = dst_base;
                    d.cnt = byte_cnt;
                    d.cf  = cfg;
                    d.idx = '0;
                end
            end
            ST_WAIT: begin
                d.idx = '0;
                if (!dreq_n) d.st = q.cf.saa ? ST_SACC : ST_READ;
            end
            ST_READ: begin
                if (bus_ready) begin
                    d.sa = q.sa + s_step;
                    if (q.idx == rd_last) begin
                        d.st  = ST_WRITE;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + IDXW'(1);
                    end
                end
            end
            ST_WRITE: begin
                if (bus_ready) begin
                    d.da     = q.da + d_step;
                    cnt_next = q.cnt - d_step;
                    d.cnt    = cnt_next;
                    if (q.idx == wr_last) begin
                        d.idx = '0;
                        if (cnt_next == '0)  d.st = ST_IDLE;
                        else if (q.cf.cont)  d.st = ST_READ;
                        else                 d.st = ST_WAIT;
                    end else begin
                        d.idx = q.idx + IDXW'(1);
                    end
                end
            end
            ST_SACC: begin
                if (bus_ready) begin
                    d.sa     = q.sa + s_step;
                    cnt_next = q.cnt - s_step;
                    d.cnt    = cnt_next;
                    if (cnt_next == '0)  d.st = ST_IDLE;
                    else if (q.cf.cont)  d.st = ST_SACC;
                    else                 d.st = ST_WAIT;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        eng_busy  = (q.st != ST_IDLE);
        bus_valid = (q.st == ST_READ) || (q.st == ST_WRITE) || (q.st == ST_SACC);
        bus_write = (q.st == ST_WRITE);
        bus_addr  = bus_write ? q.da : q.sa;
        bus_size  = bus_write ? q.cf.dsz : q.cf.ssz;
        tm_code   = (q.cf.at || last_acc) ? CHAN_CODE : 2'b00;
        bus_tt    = bus_valid ? 2'b01 : 2'b00;
        bus_tm    = bus_valid ? {tm_code, q.cf.saa} : 3'b000;
        cap_en    = (q.st == ST_READ) && bus_ready;
        cap_off   = OFFW'(q.idx << slg);
        cap_lg    = slg;
        ext_off   = OFFW'(q.idx << dlg);
        ext_lg    = dlg;
    end

endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
    import dma_ch_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BUF_BYTES = 16,
    parameter int CHAN_ID   = 0,
    localparam int DW   = BUF_BYTES * 8,
    localparam int OFFW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    input  logic          dreq_n,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic [1:0]    bus_tt,
    output logic [2:0]    bus_tm
);

    logic [AW-1:0]   src_base, dst_base, byte_cnt;
    xfer_cfg_t       cfg;
    logic            start, eng_busy, done_evt, cap_en;
    logic [OFFW-1:0] cap_off, ext_off;
    logic [2:0]      cap_lg, ext_lg;

    dma_ch_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .eng_busy(eng_busy), .done_evt(done_evt),
        .src_base(src_base), .dst_base(dst_base), .byte_cnt(byte_cnt),
        .cfg(cfg), .start(start), .busy(busy), .done(done), .err(err)
    );

    dma_ch_seq #(.AW(AW), .OFFW(OFFW), .CHAN_ID(CHAN_ID)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base), .byte_cnt(byte_cnt),
        .cfg(cfg), .dreq_n(dreq_n), .bus_ready(bus_ready),
        .eng_busy(eng_busy), .done_evt(done_evt),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_tt(bus_tt), .bus_tm(bus_tm),
        .cap_en(cap_en), .cap_off(cap_off), .cap_lg(cap_lg),
        .ext_off(ext_off), .ext_lg(ext_lg)
    );

    dma_ch_stage #(.BUF_BYTES(BUF_BYTES)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_off(cap_off), .cap_lg(cap_lg), .cap_data(bus_rdata),
        .ext_off(ext_off), .ext_lg(ext_lg), .ext_data(bus_wdata)
    );

endmodule

// File: rtl/dma_ch_chk.sv
module dma_ch_chk #(
    parameter int AW = 32,
    parameter int DW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ready,
    input logic [1:0]    bus_tt,
    input logic [2:0]    bus_tm
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid);

    assert_err_no_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    assert_done_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

    assert_type_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tt == 2'b01));

    assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tm[2:1] != 2'b11));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)
            && $stable(bus_size) && $stable(bus_wdata) && $stable(bus_tt) && $stable(bus_tm)));

endmodule

bind dma_xfer_channel dma_ch_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_tt(bus_tt), .bus_tm(bus_tm)
);

// File: tb/tb_dma_xfer_channel.sv
`timescale 1ns/1ps
module tb_dma_xfer_channel;

    localparam int AW = 32;
    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic          busy, done, err;
    logic          dreq_n = 1'b1;
    logic          bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic [1:0]    bus_tt;
    logic [2:0]    bus_tm;

    dma_xfer_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .busy(busy), .done(done), .err(err), .dreq_n(dreq_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_tt(bus_tt), .bus_tm(bus_tm)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // transfer under test, as the bench expects it
    logic [1:0]  cs, cd;
    logic        c_at, c_saa, c_cont;
    logic [31:0] src_b, dst_b, cnt_b;
    int          rd_b, wr_b, gaps;
    bit          hold_final, final_pending;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [31:0] a);
        return 8'(a * 7 + 32'h5B);
    endfunction

    function automatic int bytes_of(input logic [1:0] c);
        return (c == 2'b11) ? 16 : (1 << c);
    endfunction

    task automatic check_access(input bit is_final);
        int sb, db;
        logic [127:0] expd;
        sb = bytes_of(cs);
        db = bytes_of(cd);
        chk(bus_tt == 2'b01, "R5 type tag", bus_tt, 2'b01);
        chk(bus_tm[0] == c_saa, "R5 single flag", bus_tm[0], c_saa);
        chk(bus_tm[2:1] == ((c_at || is_final) ? 2'b01 : 2'b00), "R6 channel code",
            bus_tm[2:1], (c_at || is_final) ? 2'b01 : 2'b00);
        if (!bus_write) begin
            chk(bus_addr == src_b + rd_b, "R4 source address", bus_addr, src_b + rd_b);
            chk(bus_size == cs, "R3 read size", bus_size, cs);
            bus_rdata = '0;
            for (int i = 0; i < sb; i++) bus_rdata[i*8 +: 8] = pat(bus_addr + i);
            rd_b += sb;
        end else begin
            chk(!c_saa, "R7 no write in single mode", bus_write, 0);
            chk(wr_b + db <= rd_b, "R3 write after read", wr_b + db, rd_b);
            chk(bus_addr == dst_b + wr_b, "R4 destination address", bus_addr, dst_b + wr_b);
            chk(bus_size == cd, "R3 write size", bus_size, cd);
            expd = '0;
            for (int i = 0; i < db; i++) expd[i*8 +: 8] = pat(src_b + wr_b + i);
            chk(bus_wdata == expd, "R3 write data", bus_wdata, expd);
            wr_b += db;
        end
    endtask

    // called once per negedge: sample outputs, then drive ready/data
    task automatic serve();
        bit is_final;
        bus_ready = 1'b0;
        final_pending = 1'b0;
        if (busy && !bus_valid && rd_b > 0) gaps++;
        if (bus_valid) begin
            is_final = c_saa ? (rd_b + bytes_of(cs) == cnt_b) :
                               (bus_write && (wr_b + bytes_of(cd) == cnt_b));
            if (hold_final && is_final) final_pending = 1'b1;
            else begin
                bus_ready = 1'b1;
                check_access(is_final);
            end
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        bus_ready = 1'b0;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [1:0] s, input logic [1:0] d_, input logic at,
                                              input logic saa, input logic cont, input logic go);
        return {22'd0, 1'b0, 1'b1, cont, saa, at, d_, s, go};
    endfunction

    task automatic setup(input logic [1:0] s, input logic [1:0] d_, input logic at, input logic saa,
                         input logic cont, input logic [31:0] sa, input logic [31:0] da, input logic [31:0] n);
        cs = s; cd = d_; c_at = at; c_saa = saa; c_cont = cont;
        src_b = sa; dst_b = da; cnt_b = n;
        rd_b = 0; wr_b = 0; gaps = 0; hold_final = 1'b0;
        reg_write(2'd0, sa);
        reg_write(2'd1, da);
        reg_write(2'd2, n);
        reg_write(2'd3, ctrl_word(s, d_, at, saa, cont, 1'b1));
    endtask

    task automatic run_to_done(input int limit);
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            serve();
            if (done) break;
        end
        bus_ready = 1'b0;
    endtask

    // {src size, dst size, at, saa, cont, count}
    localparam logic [14:0] VEC [7] = '{
        {2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 8'd16},
        {2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 8'd8},
        {2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 8'd8},
        {2'b11, 2'b01, 1'b1, 1'b0, 1'b1, 8'd32},
        {2'b01, 2'b11, 1'b0, 1'b0, 1'b1, 8'd16},
        {2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 8'd4},
        {2'b10, 2'b10, 1'b1, 1'b1, 1'b1, 8'd8}
    };

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
        chk(!bus_valid && bus_tt == 0 && bus_tm == 0, "R1 reset bus", {bus_valid, bus_tt, bus_tm}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: continuous and single-address transfers
        foreach (VEC[v]) begin
            setup(VEC[v][14:13], VEC[v][12:11], VEC[v][10], VEC[v][9], VEC[v][8],
                  32'h1000 + v * 256, 32'h8000 + v * 256, {24'd0, VEC[v][7:0]});
            chk(busy && !err, "R2 valid start", {busy, err}, 2'b10);
            dreq_n = 1'b0;
            run_to_done(400);
            dreq_n = 1'b1;
            chk(done && !busy, "R4 completion", {done, busy}, 2'b10);
            chk(rd_b == cnt_b, "R3 bytes read", rd_b, cnt_b);
            chk(wr_b == (c_saa ? 0 : cnt_b), "R7 bytes written", wr_b, c_saa ? 0 : cnt_b);
            chk(gaps == 0, "R9 continuous without gap", gaps, 0);
        end

        // R8: request held high -> no access
        setup(2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 32'h2000, 32'h9000, 32'd8);
        for (int k = 0; k < 12; k++) begin @(negedge clk); serve(); end
        chk(rd_b == 0 && busy, "R8 idle request", {rd_b, busy}, 1);
        @(negedge clk); dreq_n = 1'b0;
        @(negedge clk); dreq_n = 1'b1;   // single request, continuous mode
        run_to_done(200);
        chk(done && wr_b == 8, "R9 continuous from one request", wr_b, 8);

        // R9 cycle-steal, one unit per request; R12 writes while busy ignored
        setup(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 32'h3000, 32'hA000, 32'd8);
        @(negedge clk); dreq_n = 1'b0;
        @(negedge clk); dreq_n = 1'b1;
        for (int k = 0; k < 20; k++) begin @(negedge clk); serve(); end
        chk(rd_b == 4 && wr_b == 4 && busy && !done, "R9 one unit per request", {rd_b, wr_b}, {32'd4, 32'd4});
        reg_write(2'd0, 32'hDEAD0000);
        reg_write(2'd2, 32'd3);
        reg_write(2'd3, ctrl_word(2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1));
        chk(!err && busy, "R12 start while busy ignored", {err, busy}, 2'b01);
        @(negedge clk); dreq_n = 1'b0;
        @(negedge clk); dreq_n = 1'b1;
        run_to_done(200);
        chk(done && wr_b == 8, "R12 resumes unaffected", wr_b, 8);
        rd_b = 0; wr_b = 0; gaps = 0;
        reg_write(2'd3, ctrl_word(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1));
        dreq_n = 1'b0;
        run_to_done(200);
        dreq_n = 1'b1;
        chk(done && rd_b == 8, "R12 earlier bases kept", rd_b, 8);
        chk(gaps == 1, "R9 cycle-steal releases bus", gaps, 1);

        // R2 refusals
        reg_write(2'd2, 32'd0);
        reg_write(2'd3, ctrl_word(2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1));
        chk(err && !busy, "R2 zero count refused", {err, busy}, 2'b10);
        reg_write(2'd3, 32'h200);
        chk(!err, "R2 error clear", err, 0);
        reg_write(2'd2, 32'd6);
        reg_write(2'd3, 32'h200 | ctrl_word(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1));
        chk(err && !busy, "R2 set wins over clear", {err, busy}, 2'b10);
        reg_write(2'd3, 32'h200);
        setup(2'b01, 2'b11, 1'b0, 1'b1, 1'b1, 32'h4000, 32'hB000, 32'd6);
        chk(!err && busy, "R2 single mode uses source unit", {err, busy}, 2'b01);
        dreq_n = 1'b0;
        run_to_done(200);
        dreq_n = 1'b1;
        chk(done && rd_b == 6, "R7 single mode count", rd_b, 6);

        // R11 completion coincides with clearing write; stall exercises R10
        setup(2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 32'h5000, 32'hC000, 32'd8);
        hold_final = 1'b1;
        dreq_n = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            serve();
            if (final_pending) break;
        end
        repeat (3) begin @(negedge clk); serve(); end
        chk(final_pending && !done, "R10 held final write", final_pending, 1);
        bus_ready = 1'b1;
        check_access(1'b1);
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h100;
        @(negedge clk);
        reg_wr = 1'b0; bus_ready = 1'b0; dreq_n = 1'b1; hold_final = 1'b0;
        chk(done && !busy, "R11 set wins over clear", {done, busy}, 2'b10);
        reg_write(2'd3, 32'h100);
        chk(!done, "R11 done cleared", done, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule